// File: doc/BRIEF.md
# Sound CPU address decoder

This block is the combinational glue between an 8-bit sound processor and its memories and peripherals. The processor has a 16-bit address bus. The block watches that bus and the processor's memory-request, I/O-request, read and write strobes. From them it drives active-low chip selects for four memory regions and for six exported I/O strobes.

The memory regions are the program ROM space, an internal 2 KB RAM, a window that holds a 256-byte shared RAM, and the external sound data ROM. The block also produces the RAM indices with the aliasing already folded in. The internal RAM index is address bits 10:0. The shared RAM index is address bits 7:0.

The external ROM's data lines are wired in a scrambled order, so the block also steers the read data. During a memory read of the sound ROM region it swaps bits 1 to 6 of the ROM byte back into CPU order. On every other cycle it passes the ordinary data bus through unchanged.

Top module: `sc_addr_dec`

## Requirements
- R1: During a memory cycle (mreq_ni low, iorq_ni high, and rd_ni or wr_ni low), an address in 0x0000–0x1FFF drives prog_cs_no low. A write strobe alone is enough.
- R2: In a memory cycle, addresses 0x2000–0x3FFF drive iram_cs_no low. iram_idx_o always equals addr_i[10:0], so the four 2 KB copies in that range alias.
- R3: In a memory cycle, addresses 0x4000–0x7FFF drive win_cs_no low. sram_idx_o always equals addr_i[7:0], so the 256 shared bytes repeat through the window.
- R4: In a memory cycle, addresses 0x8000–0xFFFF drive snd_rom_cs_no low.
- R5: With mreq_ni low but both rd_ni and wr_ni high, all four memory selects stay high.
- R6: During an I/O cycle (iorq_ni low, mreq_ni high), the code n in addr_i[6:4] drives io_cs_no[n] low for n = 0 to 5. Bits 15:7 and 3:0 have no effect. With iorq_ni high, every io_cs_no bit is high.
- R7: I/O codes 6 and 7 are decoded to no exported strobe, so all io_cs_no bits stay high.
- R8: With both request strobes high, or both low, every select is high. At most one select of the ten is low at any time.
- R9: On a memory read (rd_ni low) of the sound ROM region, rd_data_o bit i is taken from rom_data_i bit 7-i for i = 1 to 6, while bits 0 and 7 pass straight through. On every other cycle, rd_data_o equals bus_data_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 16 | Processor address bus |
| mreq_ni | input | 1 | Memory request, active low |
| iorq_ni | input | 1 | I/O request, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| rom_data_i | input | 8 | Data from the external sound ROM, in ROM pin order |
| bus_data_i | input | 8 | Data from all other devices |
| prog_cs_no | output | 1 | Program space select, 0x0000–0x1FFF |
| iram_cs_no | output | 1 | Internal RAM select, 0x2000–0x3FFF |
| win_cs_no | output | 1 | Shared window select, 0x4000–0x7FFF |
| snd_rom_cs_no | output | 1 | Sound ROM select, 0x8000–0xFFFF |
| io_cs_no | output | 6 | I/O strobes for codes 0 to 5 |
| iram_idx_o | output | 11 | Internal RAM index, aliased |
| sram_idx_o | output | 8 | Shared RAM index, aliased |
| rd_data_o | output | 8 | Read data to the processor |

## Verification
A vector table covers the following patterns:
- Each region's first and last address, which separates the region boundaries at bits 13, 14 and 15.
- A write-only memory cycle, which tells "read or write" gating apart from read-only gating.
- A request with no strobe, and both requests at once.
- I/O addresses with all the ignored bits set, and the codes 6 and 7 that select nothing.

Full sweeps of all 65536 addresses follow, once in memory read cycles and once in I/O cycles. Each sweep is checked against a model written from the requirements, so any wrong address bit in the decode or the index outputs shows up.

Single-bit and mixed ROM bytes tell the bit-reversed swap apart from a full reversal or no swap. Reads of other regions and sound ROM writes confirm that the swap applies to one path only.

// File: rtl/sc_dec_pkg.sv
package sc_dec_pkg;
  typedef enum logic [1:0] {
    REG_PROG = 2'd0,
    REG_IRAM = 2'd1,
    REG_WIN  = 2'd2,
    REG_SROM = 2'd3
  } mem_region_e;

  localparam int unsigned NUM_REGIONS = 4;
endpackage

// File: rtl/sc_mem_decode.sv
module sc_mem_decode
  import sc_dec_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned IRAM_AW = 11,
  parameter int unsigned SRAM_AW = 8
) (
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   mem_act_i,
  output logic [NUM_REGIONS-1:0] cs_no,
  output logic [IRAM_AW-1:0]     iram_idx_o,
  output logic [SRAM_AW-1:0]     sram_idx_o
);
  mem_region_e region;

  // upper half, then next quarter, then next eighth; rest is program space
  always_comb begin
    if (addr_i[ADDR_W-1])      region = REG_SROM;
    else if (addr_i[ADDR_W-2]) region = REG_WIN;
    else if (addr_i[ADDR_W-3]) region = REG_IRAM;
    else                       region = REG_PROG;
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cs
    assign cs_no[g] = !(mem_act_i && (region == mem_region_e'(g)));
  end

  assign iram_idx_o = addr_i[IRAM_AW-1:0];
  assign sram_idx_o = addr_i[SRAM_AW-1:0];

  logic unused_hi;
  assign unused_hi = ^addr_i[ADDR_W-4:IRAM_AW];
endmodule

// File: rtl/sc_io_decode.sv
module sc_io_decode #(
  parameter int unsigned SEL_W = 3,
  parameter int unsigned N_OUT = 6
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             io_act_i,
  output logic [N_OUT-1:0] io_cs_no
);
  localparam int unsigned N_DEC = 1 << SEL_W;

  // codes N_OUT..N_DEC-1 decode to nothing exported
  for (genvar g = 0; g < N_OUT && g < N_DEC; g++) begin : g_io
    assign io_cs_no[g] = !(io_act_i && (sel_i == SEL_W'(g)));
  end
endmodule

// File: rtl/sc_rom_swizzle.sv
module sc_rom_swizzle #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] rom_i,
  output logic [DATA_W-1:0] cpu_o
);
  // end bits fixed, inner bits mirrored
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    localparam int unsigned SRC = (g == 0 || g == DATA_W-1) ? g : DATA_W-1-g;
    assign cpu_o[g] = rom_i[SRC];
  end
endmodule

// File: rtl/sc_addr_dec.sv
module sc_addr_dec
  import sc_dec_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned IRAM_AW    = 11,
  parameter int unsigned SRAM_AW    = 8,
  parameter int unsigned IO_SEL_LSB = 4,
  parameter int unsigned IO_SEL_W   = 3,
  parameter int unsigned IO_N       = 6
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               mreq_ni,
  input  logic               iorq_ni,
  input  logic               rd_ni,
  input  logic               wr_ni,
  input  logic [DATA_W-1:0]  rom_data_i,
  input  logic [DATA_W-1:0]  bus_data_i,
  output logic               prog_cs_no,
  output logic               iram_cs_no,
  output logic               win_cs_no,
  output logic               snd_rom_cs_no,
  output logic [IO_N-1:0]    io_cs_no,
  output logic [IRAM_AW-1:0] iram_idx_o,
  output logic [SRAM_AW-1:0] sram_idx_o,
  output logic [DATA_W-1:0]  rd_data_o
);
  logic                   mem_act, io_act;
  logic [NUM_REGIONS-1:0] mem_cs_n;
  logic [DATA_W-1:0]      rom_fixed;

  // both requests low is treated as neither
  assign mem_act = !mreq_ni && iorq_ni && (!rd_ni || !wr_ni);
  assign io_act  = !iorq_ni && mreq_ni;

  sc_mem_decode #(
    .ADDR_W (ADDR_W),
    .IRAM_AW(IRAM_AW),
    .SRAM_AW(SRAM_AW)
  ) u_mem (
    .addr_i    (addr_i),
    .mem_act_i (mem_act),
    .cs_no     (mem_cs_n),
    .iram_idx_o(iram_idx_o),
    .sram_idx_o(sram_idx_o)
  );

  sc_io_decode #(
    .SEL_W(IO_SEL_W),
    .N_OUT(IO_N)
  ) u_io (
    .sel_i   (addr_i[IO_SEL_LSB +: IO_SEL_W]),
    .io_act_i(io_act),
    .io_cs_no(io_cs_no)
  );

  sc_rom_swizzle #(.DATA_W(DATA_W)) u_swz (
    .rom_i(rom_data_i),
    .cpu_o(rom_fixed)
  );

  assign prog_cs_no    = mem_cs_n[REG_PROG];
  assign iram_cs_no    = mem_cs_n[REG_IRAM];
  assign win_cs_no     = mem_cs_n[REG_WIN];
  assign snd_rom_cs_no = mem_cs_n[REG_SROM];

  assign rd_data_o = (!mem_cs_n[REG_SROM] && !rd_ni) ? rom_fixed : bus_data_i;
endmodule

// File: rtl/sc_addr_dec_chk.sv
module sc_addr_dec_chk (
  input logic [15:0] addr_i,
  input logic        mreq_ni,
  input logic        iorq_ni,
  input logic        rd_ni,
  input logic [7:0]  bus_data_i,
  input logic        prog_cs_no,
  input logic        iram_cs_no,
  input logic        win_cs_no,
  input logic        snd_rom_cs_no,
  input logic [5:0]  io_cs_no,
  input logic [7:0]  rd_data_o
);
  logic [3:0] mem_n;
  assign mem_n = {snd_rom_cs_no, win_cs_no, iram_cs_no, prog_cs_no};

  always_comb begin
    if (!$isunknown({addr_i, mreq_ni, iorq_ni, rd_ni, bus_data_i, mem_n, io_cs_no, rd_data_o})) begin
      AST_ONE_SELECT: assert ($onehot0({~mem_n, ~io_cs_no})) else $error("multiple selects"); // R8
      AST_IDLE_HIGH: assert (!(mreq_ni == iorq_ni) || (&mem_n && &io_cs_no)) else $error("select while idle"); // R8
      AST_PROG_RANGE: assert (prog_cs_no || (addr_i[15:13] == 3'b000 && !mreq_ni)) else $error("prog range"); // R1
      AST_SROM_RANGE: assert (snd_rom_cs_no || (addr_i[15] && !mreq_ni)) else $error("srom range"); // R4
      AST_IO_GATED: assert (!iorq_ni || &io_cs_no) else $error("io without iorq"); // R6
      AST_PASS_NO_READ: assert (!rd_ni || rd_data_o == bus_data_i) else $error("data altered"); // R9
    end
  end
endmodule

bind sc_addr_dec sc_addr_dec_chk u_chk (
  .addr_i       (addr_i),
  .mreq_ni      (mreq_ni),
  .iorq_ni      (iorq_ni),
  .rd_ni        (rd_ni),
  .bus_data_i   (bus_data_i),
  .prog_cs_no   (prog_cs_no),
  .iram_cs_no   (iram_cs_no),
  .win_cs_no    (win_cs_no),
  .snd_rom_cs_no(snd_rom_cs_no),
  .io_cs_no     (io_cs_no),
  .rd_data_o    (rd_data_o)
);

// File: tb/tb_sc_addr_dec.sv
module tb_sc_addr_dec;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic        mreq_ni = 1'b1, iorq_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [7:0]  rom_data_i = '0, bus_data_i = '0;
  logic        prog_cs_no, iram_cs_no, win_cs_no, snd_rom_cs_no;
  logic [5:0]  io_cs_no;
  logic [10:0] iram_idx_o;
  logic [7:0]  sram_idx_o, rd_data_o;
  logic [3:0]  mem_n;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sc_addr_dec dut (
    .addr_i(addr_i), .mreq_ni(mreq_ni), .iorq_ni(iorq_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
    .rom_data_i(rom_data_i), .bus_data_i(bus_data_i),
    .prog_cs_no(prog_cs_no), .iram_cs_no(iram_cs_no), .win_cs_no(win_cs_no),
    .snd_rom_cs_no(snd_rom_cs_no), .io_cs_no(io_cs_no),
    .iram_idx_o(iram_idx_o), .sram_idx_o(sram_idx_o), .rd_data_o(rd_data_o)
  );

  assign mem_n = {snd_rom_cs_no, win_cs_no, iram_cs_no, prog_cs_no};

  // {req, addr, mreq iorq rd wr, exp mem {srom,win,iram,prog}, exp io[5:0]}
  localparam int NV = 15;
  localparam logic [37:0] VEC [NV] = '{
    {8'd1, 16'h0000, 4'b0101, 4'b1110, 6'h3F}, // R1 read, low edge
    {8'd1, 16'h1FFF, 4'b0110, 4'b1110, 6'h3F}, // R1 write only, high edge
    {8'd2, 16'h2000, 4'b0101, 4'b1101, 6'h3F}, // R2
    {8'd2, 16'h3FFF, 4'b0101, 4'b1101, 6'h3F}, // R2
    {8'd3, 16'h4000, 4'b0101, 4'b1011, 6'h3F}, // R3
    {8'd3, 16'h7FFF, 4'b0110, 4'b1011, 6'h3F}, // R3
    {8'd4, 16'h8000, 4'b0101, 4'b0111, 6'h3F}, // R4
    {8'd4, 16'hFFFF, 4'b0101, 4'b0111, 6'h3F}, // R4
    {8'd5, 16'h2000, 4'b0111, 4'b1111, 6'h3F}, // R5 no strobe
    {8'd6, 16'h0030, 4'b1001, 4'b1111, 6'h37}, // R6 code 3
    {8'd6, 16'hFF8F, 4'b1011, 4'b1111, 6'h3E}, // R6 code 0, ignored bits set
    {8'd7, 16'h0060, 4'b1011, 4'b1111, 6'h3F}, // R7 code 6
    {8'd7, 16'hFFFF, 4'b1011, 4'b1111, 6'h3F}, // R7 code 7
    {8'd8, 16'h0050, 4'b0001, 4'b1111, 6'h3F}, // R8 both requests
    {8'd8, 16'h8000, 4'b1100, 4'b1111, 6'h3F}  // R8 no request
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, addr_i, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] a, input logic [3:0] s);
    addr_i = a;
    {mreq_ni, iorq_ni, rd_ni, wr_ni} = s;
    #2;
  endtask

  function automatic logic [3:0] mdl_mem(input logic [15:0] a);
    if (a >= 16'h8000)      return 4'b0111;
    else if (a >= 16'h4000) return 4'b1011;
    else if (a >= 16'h2000) return 4'b1101;
    else                    return 4'b1110;
  endfunction

  function automatic logic [5:0] mdl_io(input logic [15:0] a);
    logic [5:0] r = 6'h3F;
    int code = (a >> 4) & 7;
    if (code < 6) r[code] = 1'b0;
    return r;
  endfunction

  function automatic logic [7:0] mdl_swz(input logic [7:0] d);
    return {d[7], d[1], d[2], d[3], d[4], d[5], d[6], d[0]};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // idle state after reset
    check("R8 idle mem", {12'h0, mem_n}, 16'hF);
    check("R8 idle io", {10'h0, io_cs_no}, 16'h3F);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][29:14], VEC[i][13:10]);
      check($sformatf("R%0d mem", VEC[i][37:30]), {12'h0, mem_n}, {12'h0, VEC[i][9:6]});
      check($sformatf("R%0d io", VEC[i][37:30]), {10'h0, io_cs_no}, {10'h0, VEC[i][5:0]});
    end

    // R2 / R3 aliasing
    drive(16'h3ABC, 4'b0101);
    check("R2 iram idx", {5'h0, iram_idx_o}, 16'h02BC);
    drive(16'h5F3C, 4'b0101);
    check("R3 sram idx", {8'h0, sram_idx_o}, 16'h003C);

    // R9 swap on sound ROM read only
    bus_data_i = 8'h5A;
    rom_data_i = 8'h02; drive(16'h8000, 4'b0101);
    check("R9 bit1", {8'h0, rd_data_o}, 16'h0040);
    rom_data_i = 8'h81; drive(16'hC123, 4'b0101);
    check("R9 ends", {8'h0, rd_data_o}, 16'h0081);
    rom_data_i = 8'h0E; drive(16'hFFFF, 4'b0101);
    check("R9 mixed", {8'h0, rd_data_o}, 16'h0070);
    rom_data_i = 8'h0E; drive(16'h4000, 4'b0101);
    check("R9 other region", {8'h0, rd_data_o}, 16'h005A);
    drive(16'h8000, 4'b0110);
    check("R9 rom write", {8'h0, rd_data_o}, 16'h005A);
    drive(16'h0080, 4'b1001);
    check("R9 io read", {8'h0, rd_data_o}, 16'h005A);
    for (int d = 0; d < 256; d += 37) begin
      rom_data_i = 8'(d); drive(16'h9000, 4'b0101);
      check("R9 sweep", {8'h0, rd_data_o}, {8'h0, mdl_swz(8'(d))});
    end

    // full sweeps R1 R2 R3 R4 R6 R7
    for (int a = 0; a < 65536; a++) begin
      drive(16'(a), 4'b0101);
      check("R1-4 sweep mem", {1'b0, sram_idx_o, 3'b0, mem_n}, {1'b0, 8'(a), 3'b0, mdl_mem(16'(a))});
      check("R2 sweep idx", {5'h0, iram_idx_o}, {5'h0, 11'(a)});
      if (io_cs_no !== 6'h3F) check("R6 sweep io in mem", {10'h0, io_cs_no}, 16'h3F);
    end
    for (int a = 0; a < 65536; a++) begin
      drive(16'(a), 4'b1011);
      check("R6 R7 sweep io", {mem_n, 6'h0, io_cs_no}, {4'hF, 6'h0, mdl_io(16'(a))});
    end

    finish_run();
  end
endmodule